// File: doc/BRIEF.md
# Accumulator Add/Subtract Datapath

This block is a small arithmetic datapath built around two registers. An accumulator holds the running result. An operand register takes a word from a memory-data input. A command interface can clear the accumulator, capture an operand, add the operand into the accumulator, or subtract it from the accumulator. Every command completes on one rising clock edge. The result stays in the accumulator for further steps or for readout.

The adder is a ripple chain of one full-adder cell per bit. Each cell's carry feeds the next more significant cell. A steering stage sits between the operand register and the chain:
- For addition it passes the operand unchanged with a carry-in of 0.
- For subtraction it passes the bitwise complement with a carry-in of 1, which forms the two's-complement difference.

The carry-out of the top cell and a signed-overflow flag are registered together with each result. To sum two numbers, the sequence is: clear, load the first operand, add, load the second operand, add.

Top module: `acc_addsub_unit`

## Requirements
- R1: A synchronous active-high reset sets the accumulator, the operand register, the carry flag and the overflow flag to zero. An add command issued right after reset leaves the accumulator at 0 with carry 0.
- R2: When `clr_acc`=1, the next rising edge sets the accumulator, carry flag and overflow flag to 0 and leaves the operand register unchanged. Clear takes priority over load and over arithmetic commands in the same cycle.
- R3: When `load_opd`=1 and `clr_acc`=0, the next edge copies `mem_data` into the operand register and leaves the accumulator and both flags unchanged. Load takes priority over `add_sel`/`sub_sel` in the same cycle.
- R4: With `add_sel`=1 and `sub_sel`=0 (and no clear or load), the next edge sets the accumulator to (accumulator + operand) mod 2^W. The carry flag is set to the carry out of bit W-1.
- R5: With `add_sel`=0 and `sub_sel`=1 (and no clear or load), the next edge sets the accumulator to (accumulator − operand) mod 2^W, computed as accumulator + ~operand + 1. The carry flag becomes 1 exactly when accumulator ≥ operand taken as unsigned values, so 0 signals a borrow.
- R6: On an add or subtract step, the overflow flag is set to 1 when both adder inputs (accumulator and the steered operand) have the same bit W-1 and the result's bit W-1 differs from it. This matches the signed result leaving −2^(W-1)..2^(W-1)−1. Otherwise the flag is set to 0.
- R7: When `add_sel` and `sub_sel` are equal and neither clear nor load is set, the accumulator and both flags hold their values.
- R8: The sequence clear, load 9, add, load 5, add leaves 14 in the accumulator with both flags 0.
- R9: The carry ripples through all W cells: 0xFF + 0x01 (W=8) gives accumulator 0x00 with carry 1 and overflow 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_acc | input | 1 | Clear accumulator and flags |
| load_opd | input | 1 | Capture `mem_data` into the operand register |
| add_sel | input | 1 | Add-select line |
| sub_sel | input | 1 | Subtract-select line |
| mem_data | input | W | Operand word from memory |
| acc_q | output | W | Accumulator value |
| carry_q | output | 1 | Registered carry out of the top cell |
| ovf_q | output | 1 | Registered signed overflow |

## Verification
Every command is sampled on a rising edge, and its effect on `acc_q`, `carry_q` and `ovf_q` is visible right after that same edge: a latency of one cycle and no more. The bench drives inputs on the falling edge and samples the outputs on the following falling edge, after exactly one rising edge. It compares them there against a reference model that it advances once per edge. The operand register is not an output, so load results are observed through the add or subtract that follows the load.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_CLEAR,
    OP_LOAD,
    OP_ADD,
    OP_SUB
  } op_e;

  // Priority: clear, then load, then a single arithmetic select.
  function automatic op_e decode_op(input logic clr, input logic ld,
                                    input logic add, input logic sub);
    if (clr)               return OP_CLEAR;
    else if (ld)           return OP_LOAD;
    else if (add && !sub)  return OP_ADD;
    else if (sub && !add)  return OP_SUB;
    else                   return OP_HOLD;
  endfunction

endpackage

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  logic hx;
  assign hx = x ^ y;
  assign s  = hx ^ ci;
  assign co = (x & y) | (hx & ci);
endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] c;
  assign c[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_cell
    fa_cell u_fa (
      .x (a[i]),
      .y (b[i]),
      .ci(c[i]),
      .s (sum[i]),
      .co(c[i+1])
    );
  end

  assign cout = c[W];
endmodule

// File: rtl/operand_steer.sv
module operand_steer #(
  parameter int W = 8
) (
  input  logic [W-1:0] b_in,
  input  logic         add_sel,
  input  logic         sub_sel,
  output logic [W-1:0] b_out,
  output logic         cin
);
  logic inv;
  assign inv   = sub_sel & ~add_sel;
  assign b_out = b_in ^ {W{inv}};
  assign cin   = inv;
endmodule

// File: rtl/acc_addsub_unit.sv
module acc_addsub_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_acc,
  input  logic         load_opd,
  input  logic         add_sel,
  input  logic         sub_sel,
  input  logic [W-1:0] mem_data,
  output logic [W-1:0] acc_q,
  output logic         carry_q,
  output logic         ovf_q
);
  import acc_pkg::*;

  localparam int MSB = W - 1;

  op_e         op;
  logic [W-1:0] b_q;
  logic [W-1:0] b_eff;
  logic [W-1:0] sum;
  logic         cin;
  logic         cout;
  logic         ovf_next;

  assign op = decode_op(clr_acc, load_opd, add_sel, sub_sel);

  operand_steer #(.W(W)) u_steer (
    .b_in   (b_q),
    .add_sel(add_sel),
    .sub_sel(sub_sel),
    .b_out  (b_eff),
    .cin    (cin)
  );

  ripple_chain #(.W(W)) u_chain (
    .a   (acc_q),
    .b   (b_eff),
    .cin (cin),
    .sum (sum),
    .cout(cout)
  );

  // Same-sign inputs with a differing result sign.
  assign ovf_next = (acc_q[MSB] == b_eff[MSB]) && (sum[MSB] != acc_q[MSB]);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      b_q     <= '0;
      carry_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      case (op)
        OP_CLEAR: begin
          acc_q   <= '0;
          carry_q <= 1'b0;
          ovf_q   <= 1'b0;
        end
        OP_LOAD: b_q <= mem_data;
        OP_ADD, OP_SUB: begin
          acc_q   <= sum;
          carry_q <= cout;
          ovf_q   <= ovf_next;
        end
        default: ;
      endcase
    end
  end

  // Checker-side wide signed results, formed without the cell chain.
  logic signed [W:0] wide_add;
  logic signed [W:0] wide_sub;
  assign wide_add = $signed({acc_q[MSB], acc_q}) + $signed({b_q[MSB], b_q});
  assign wide_sub = $signed({acc_q[MSB], acc_q}) - $signed({b_q[MSB], b_q});

  p_reset_r1: assert property (@(posedge clk) rst |=>
    (acc_q == '0) && !carry_q && !ovf_q);

  p_clear_r2: assert property (@(posedge clk) disable iff (rst)
    clr_acc |=> (acc_q == '0) && !carry_q && !ovf_q && $stable(b_q));

  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    (!clr_acc && load_opd) |=> (b_q == $past(mem_data)) && $stable(acc_q)
      && $stable(carry_q) && $stable(ovf_q));

  p_add_r4: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ADD) |=> {carry_q, acc_q} == $past({1'b0, acc_q} + {1'b0, b_q}));

  p_sub_r5: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SUB) |=> (acc_q == $past(acc_q - b_q)) && (carry_q == $past(acc_q >= b_q)));

  p_ovf_add_r6: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ADD) |=> ovf_q == $past(wide_add[W] != wide_add[MSB]));

  p_ovf_sub_r6: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SUB) |=> ovf_q == $past(wide_sub[W] != wide_sub[MSB]));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!clr_acc && !load_opd && (add_sel == sub_sel)) |=>
      $stable(acc_q) && $stable(carry_q) && $stable(ovf_q) && $stable(b_q));

endmodule

// File: tb/acc_addsub_unit_bench.sv
`timescale 1ns/1ps
module acc_addsub_unit_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         clr_acc, load_opd, add_sel, sub_sel;
  logic [W-1:0] mem_data;
  logic [W-1:0] acc_q;
  logic         carry_q, ovf_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [W-1:0] ea, eb;
  logic         ec, ev;

  always #4 clk = ~clk;

  acc_addsub_unit #(.W(W)) u_acc_addsub_unit (
    .clk(clk), .rst(rst), .clr_acc(clr_acc), .load_opd(load_opd),
    .add_sel(add_sel), .sub_sel(sub_sel), .mem_data(mem_data),
    .acc_q(acc_q), .carry_q(carry_q), .ovf_q(ovf_q)
  );

  // Returns {overflow, carry, result}.
  function automatic logic [W+1:0] ref_add(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] t;
    logic v;
    t = {1'b0, a} + {1'b0, b};
    v = (a[W-1] == b[W-1]) && (t[W-1] != a[W-1]);
    return {v, t[W], t[W-1:0]};
  endfunction

  function automatic logic [W+1:0] ref_sub(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r;
    logic v;
    r = a - b;
    v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
    return {v, (a >= b), r};
  endfunction

  task automatic check(input string tag);
    checks++;
    if ({ovf_q, carry_q, acc_q} !== {ev, ec, ea}) begin
      errors++;
      $display("FAIL %s acc=%h carry=%b ovf=%b expected acc=%h carry=%b ovf=%b",
               tag, acc_q, carry_q, ovf_q, ea, ec, ev);
    end
  endtask

  task automatic step(input logic c, input logic l, input logic a, input logic s,
                      input logic [W-1:0] d, input string tag);
    logic [W+1:0] r;
    clr_acc = c; load_opd = l; add_sel = a; sub_sel = s; mem_data = d;
    @(posedge clk);
    if (c) begin
      ea = '0; ec = 1'b0; ev = 1'b0;
    end else if (l) begin
      eb = d;
    end else if (a && !s) begin
      r = ref_add(ea, eb); {ev, ec, ea} = r;
    end else if (s && !a) begin
      r = ref_sub(ea, eb); {ev, ec, ea} = r;
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; clr_acc = 0; load_opd = 0; add_sel = 0; sub_sel = 0; mem_data = '0;
    ea = '0; eb = '0; ec = 0; ev = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset state");
    step(0, 0, 1, 0, 8'hA5, "R1 operand zero after reset");

    // R8 two-operand sum sequence
    step(1, 0, 0, 0, 8'h00, "R8 clear");
    step(0, 1, 0, 0, 8'd9,  "R8 load 9");
    step(0, 0, 1, 0, 8'h00, "R8 add 9");
    step(0, 1, 0, 0, 8'd5,  "R8 load 5");
    step(0, 0, 1, 0, 8'h00, "R8 result 14");
    if (acc_q !== 8'd14) begin
      errors++; $display("FAIL R8 acc=%0d expected 14", acc_q);
    end
    checks++;

    // R9 full ripple
    step(1, 0, 0, 0, 8'h00, "R9 clear");
    step(0, 1, 0, 0, 8'hFF, "R9 load FF");
    step(0, 0, 1, 0, 8'h00, "R9 add FF");
    step(0, 1, 0, 0, 8'h01, "R9 load 01");
    step(0, 0, 1, 0, 8'h00, "R9 FF+01 wraps with carry");

    // R6 signed overflow on add and sub
    step(1, 0, 0, 0, 8'h00, "R6 clear");
    step(0, 1, 0, 0, 8'h7F, "R6 load 7F");
    step(0, 0, 1, 0, 8'h00, "R6 add 7F");
    step(0, 1, 0, 0, 8'h01, "R6 load 01");
    step(0, 0, 1, 0, 8'h00, "R6 7F+01 overflow");
    step(1, 0, 0, 0, 8'h00, "R6 clear again");
    step(0, 1, 0, 0, 8'h80, "R6 load 80");
    step(0, 0, 0, 1, 8'h00, "R6 R5 0-80 overflow and borrow");
    step(0, 0, 0, 1, 8'h00, "R5 80-80 equal no borrow");

    // R7 both selects equal: hold
    step(0, 1, 0, 0, 8'h13, "R3 load 13");
    step(0, 0, 1, 1, 8'h00, "R7 both selects hold");
    step(0, 0, 0, 0, 8'h00, "R7 no select hold");
    // R3 load beats arithmetic; R2 clear beats everything
    step(0, 1, 1, 0, 8'h22, "R3 load over add");
    step(0, 0, 1, 0, 8'h00, "R3 add of loaded 22");
    step(1, 1, 1, 0, 8'h44, "R2 clear over load and add");
    step(0, 0, 1, 0, 8'h00, "R2 operand kept 22");

    for (int i = 0; i < 400; i++) begin
      logic [3:0] k;
      logic [W-1:0] d;
      k = 4'($urandom_range(0, 15));
      d = W'($urandom);
      case (k)
        4'd0:          step(1, $urandom_range(0,1) == 1, 1, 0, d, "R2 random clear");
        4'd1, 4'd2,
        4'd3:          step(0, 1, $urandom_range(0,1) == 1, 0, d, "R3 random load");
        4'd4, 4'd5,
        4'd6, 4'd7:    step(0, 0, 1, 0, d, "R4 random add");
        4'd8, 4'd9,
        4'd10, 4'd11:  step(0, 0, 0, 1, d, "R5 random sub");
        4'd12:         step(0, 0, 1, 1, d, "R7 random hold");
        default:       step(0, 0, 0, 0, d, "R7 random idle");
      endcase
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule